// File: doc/BRIEF.md
# Channel protection latch controller

This block holds the trip state of a group of high-voltage supply channels. Every local channel owns two sticky flags, one for over-voltage and one for over-current. Each flag is set by its own comparator input, which is synchronised first. From the flags, the module enable and a jumper-selected current mode, the block drives one shut-off line per channel. An over-voltage trip always shuts the channel off. An over-current trip shuts it off only when the jumper selects kill. In constant-current mode the channel keeps running and the analog limit holds the current.

The supervising controller can force the flags of one channel, or of every channel, to set or to clear. A channel select picks whose two flags appear on a pair of status outputs. Channel numbers above the local group belong to a companion board. For those numbers the companion's status inputs are passed straight through. The analog limit sources and the comparators sit outside the block.

Top module: `prot_ctl`

## Requirements
- R1: While `rst_n` is low, all flags are clear. Asserting `rst_n` low clears them at once, without waiting for a clock. `chan_off` then equals `~mod_en` on every bit, and the status outputs show zero for a local channel.
- R2: `ov_trip[i]` high at one rising edge sets the over-voltage flag of channel i by the second edge after it. `chan_off[i]` is then 1 in either current mode, and not before that edge.
- R3: With `cc_mode` = 0 (kill), a set over-current flag of channel i drives `chan_off[i]` to 1, with the same latency as R2.
- R4: With `cc_mode` = 1 (constant current), a set over-current flag does not raise `chan_off[i]`. The flag still reads 1 on `stat_oc`.
- R5: A flag stays set after its trip input returns low, until a clear command or a reset.
- R6: A command with `cmd_valid` = 1, `cmd_set` = 0 and `cmd_all` = 0 clears both flags of channel `cmd_ch` at the next edge. It leaves every other channel unchanged.
- R7: A clear with `cmd_all` = 1 clears both flags of every local channel, whatever the value of `cmd_ch`.
- R8: A command with `cmd_set` = 1 sets both flags of channel `cmd_ch` at the next edge. With `cmd_all` = 1 it sets the flags of every local channel.
- R9: Set has priority. A synchronised trip input that is still high during a clear keeps its flag set.
- R10: `mod_en` = 0 drives every `chan_off` bit to 1 and leaves the flags unchanged.
- R11: For `sel_ch` < 6, `stat_ov` and `stat_oc` show the flags of channel `sel_ch` (bit i of the trip and off vectors is channel i). For `sel_ch` >= 6, they equal `rmt_ov_flag` and `rmt_oc_flag`.
- R12: A single-channel command whose `cmd_ch` is 6 or higher changes no local flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_en | input | 1 | Module enable; 0 shuts every channel off |
| cc_mode | input | 1 | Over-current response: 1 constant current, 0 kill |
| ov_trip | input | 6 | Over-voltage comparator inputs, bit i for channel i |
| oc_trip | input | 6 | Over-current comparator inputs, bit i for channel i |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_set | input | 1 | 1 sets flags, 0 clears flags |
| cmd_all | input | 1 | Apply the command to every local channel |
| cmd_ch | input | 4 | Target channel of a single-channel command |
| sel_ch | input | 4 | Channel whose flags drive the status outputs |
| rmt_ov_flag | input | 1 | Over-voltage status from the companion board |
| rmt_oc_flag | input | 1 | Over-current status from the companion board |
| chan_off | output | 6 | Per-channel shut-off, 1 disables the channel |
| stat_ov | output | 1 | Over-voltage flag of the selected channel |
| stat_oc | output | 1 | Over-current flag of the selected channel |

## Verification
On every cycle the assertions check four things. A trip input seen three edges back has forced its channel off. A disabled module shuts all channels off. A remote selection passes the companion flags through. A set-all command leaves every flag set. They also check that no flag drops without a command, and that constant-current mode never shuts off a channel free of over-voltage. The exact latency from trip to shut-off, the set priority during a clear, single-channel clears that spare neighbours, and an out-of-range command target are shown only by the bench scenarios. Those scenarios are compared each cycle against the behavioural model.

// File: rtl/prot_pkg.sv
package prot_pkg;
  // Meaning of the cmd_set input
  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_SET   = 1'b1
  } prot_op_e;

  // Over-current response selected by the jumper input
  typedef enum logic {
    OC_KILL  = 1'b0,
    OC_LIMIT = 1'b1
  } oc_mode_e;
endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/prot_latch_bank.sv
module prot_latch_bank
  import prot_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ov_s,
  input  logic [NCH-1:0] oc_s,
  input  logic           cmd_valid,
  input  prot_op_e       cmd_op,
  input  logic           cmd_all,
  input  logic [AW-1:0]  cmd_ch,
  output logic [NCH-1:0] ov_q,
  output logic [NCH-1:0] oc_q
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ov_d;
  logic [NCH-1:0] oc_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] IDX = AW'(i);
    logic force_set, force_clr;

    always_comb begin
      hit[i]    = cmd_valid & (cmd_all | (cmd_ch == IDX));
      force_set = hit[i] & (cmd_op == OP_SET);
      force_clr = hit[i] & (cmd_op == OP_CLEAR);
      // set terms win over the clear term
      ov_d[i]   = ov_s[i] | force_set | (ov_q[i] & ~force_clr);
      oc_d[i]   = oc_s[i] | force_set | (oc_q[i] & ~force_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ov_q[i] <= 1'b0;
        oc_q[i] <= 1'b0;
      end else begin
        ov_q[i] <= ov_d[i];
        oc_q[i] <= oc_d[i];
      end
    end
  end
endmodule

// File: rtl/prot_stat_mux.sv
module prot_stat_mux #(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic [NCH-1:0] ov_q,
  input  logic [NCH-1:0] oc_q,
  input  logic [AW-1:0]  sel_ch,
  input  logic           rmt_ov,
  input  logic           rmt_oc,
  output logic           stat_ov,
  output logic           stat_oc
);
  always_comb begin
    stat_ov = rmt_ov;
    stat_oc = rmt_oc;
    for (int i = 0; i < NCH; i++) begin
      if (sel_ch == AW'(i)) begin
        stat_ov = ov_q[i];
        stat_oc = oc_q[i];
      end
    end
  end
endmodule

// File: rtl/prot_ctl.sv
module prot_ctl
  import prot_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mod_en,
  input  logic           cc_mode,
  input  logic [NCH-1:0] ov_trip,
  input  logic [NCH-1:0] oc_trip,
  input  logic           cmd_valid,
  input  logic           cmd_set,
  input  logic           cmd_all,
  input  logic [AW-1:0]  cmd_ch,
  input  logic [AW-1:0]  sel_ch,
  input  logic           rmt_ov_flag,
  input  logic           rmt_oc_flag,
  output logic [NCH-1:0] chan_off,
  output logic           stat_ov,
  output logic           stat_oc
);
  logic [1:0]     rst_pipe_q;
  logic           rst_sync_n;
  logic [NCH-1:0] ov_s, oc_s;
  logic [NCH-1:0] lat_ov, lat_oc;
  oc_mode_e       oc_mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  prot_sync #(.W(2*NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  ({oc_trip, ov_trip}),
    .dout ({oc_s, ov_s})
  );

  prot_latch_bank #(.NCH(NCH), .AW(AW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ov_s     (ov_s),
    .oc_s     (oc_s),
    .cmd_valid(cmd_valid),
    .cmd_op   (prot_op_e'(cmd_set)),
    .cmd_all  (cmd_all),
    .cmd_ch   (cmd_ch),
    .ov_q     (lat_ov),
    .oc_q     (lat_oc)
  );

  prot_stat_mux #(.NCH(NCH), .AW(AW)) u_mux (
    .ov_q   (lat_ov),
    .oc_q   (lat_oc),
    .sel_ch (sel_ch),
    .rmt_ov (rmt_ov_flag),
    .rmt_oc (rmt_oc_flag),
    .stat_ov(stat_ov),
    .stat_oc(stat_oc)
  );

  assign oc_mode = oc_mode_e'(cc_mode);

  always_comb begin
    chan_off = {NCH{~mod_en}} | lat_ov;
    if (oc_mode == OC_KILL) chan_off = chan_off | lat_oc;
  end
endmodule

// File: rtl/prot_ctl_chk.sv
module prot_ctl_chk #(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_q,
  input logic           mod_en,
  input logic           cc_mode,
  input logic [NCH-1:0] ov_trip,
  input logic           cmd_valid,
  input logic           cmd_set,
  input logic           cmd_all,
  input logic [AW-1:0]  sel_ch,
  input logic           rmt_ov_flag,
  input logic           rmt_oc_flag,
  input logic [NCH-1:0] chan_off,
  input logic           stat_ov,
  input logic           stat_oc,
  input logic [NCH-1:0] lat_ov,
  input logic [NCH-1:0] lat_oc
);
  localparam logic [AW-1:0] NCH_A = AW'(NCH);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              warm <= 2'd0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R2
    ov_kill_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (warm == 2'd3) && $past(ov_trip[i], 3) |-> chan_off[i]);
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (warm != 2'd0) && !$past(cmd_valid) && $past(lat_ov[i]) && $past(lat_oc[i])
      |-> lat_ov[i] && lat_oc[i]);
  end

  // R10
  mod_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !mod_en |-> (&chan_off));

  // R11
  remote_stat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_ch >= NCH_A) |-> (stat_ov == rmt_ov_flag) && (stat_oc == rmt_oc_flag));

  // R8
  set_all_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (warm != 2'd0) && $past(cmd_valid && cmd_set && cmd_all) |-> (&lat_ov) && (&lat_oc));

  // R4
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cc_mode && mod_en && (lat_ov == '0) |-> (chan_off == '0));
endmodule

bind prot_ctl prot_ctl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_q      (rst_sync_n),
  .mod_en     (mod_en),
  .cc_mode    (cc_mode),
  .ov_trip    (ov_trip),
  .cmd_valid  (cmd_valid),
  .cmd_set    (cmd_set),
  .cmd_all    (cmd_all),
  .sel_ch     (sel_ch),
  .rmt_ov_flag(rmt_ov_flag),
  .rmt_oc_flag(rmt_oc_flag),
  .chan_off   (chan_off),
  .stat_ov    (stat_ov),
  .stat_oc    (stat_oc),
  .lat_ov     (lat_ov),
  .lat_oc     (lat_oc)
);

// File: tb/tb_prot_ctl.sv
`timescale 1ns/100ps
module tb_prot_ctl;
  localparam int NCH = 6;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n, mod_en, cc_mode;
  logic [NCH-1:0] ov_trip, oc_trip;
  logic cmd_valid, cmd_set, cmd_all;
  logic [AW-1:0] cmd_ch, sel_ch;
  logic rmt_ov_flag, rmt_oc_flag;
  logic [NCH-1:0] chan_off;
  logic stat_ov, stat_oc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  prot_ctl #(.NCH(NCH), .AW(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .cc_mode(cc_mode),
    .ov_trip(ov_trip), .oc_trip(oc_trip), .cmd_valid(cmd_valid),
    .cmd_set(cmd_set), .cmd_all(cmd_all), .cmd_ch(cmd_ch), .sel_ch(sel_ch),
    .rmt_ov_flag(rmt_ov_flag), .rmt_oc_flag(rmt_oc_flag),
    .chan_off(chan_off), .stat_ov(stat_ov), .stat_oc(stat_oc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [NCH-1:0] m_ov, m_oc;
  logic [NCH-1:0] ovh[$], och[$];
  int live;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov = '0; m_oc = '0; ovh.delete(); och.delete(); live = 0;
    end else if (live < 2) begin
      live++;
    end else begin
      logic [NCH-1:0] sv, sc;
      sv = (ovh.size() >= 2) ? ovh[ovh.size()-2] : '0;
      sc = (och.size() >= 2) ? och[och.size()-2] : '0;
      for (int i = 0; i < NCH; i++) begin
        bit tgt;
        tgt = cmd_valid && (cmd_all || (int'(cmd_ch) == i));
        if (tgt && cmd_set)       begin m_ov[i] = 1'b1; m_oc[i] = 1'b1; end
        else if (tgt && !cmd_set) begin m_ov[i] = 1'b0; m_oc[i] = 1'b0; end
        if (sv[i]) m_ov[i] = 1'b1;
        if (sc[i]) m_oc[i] = 1'b1;
      end
      ovh.push_back(ov_trip); och.push_back(oc_trip);
      if (ovh.size() > 4) begin void'(ovh.pop_front()); void'(och.pop_front()); end
    end
  end

  // compare every cycle, half a period after the driving edge
  always @(negedge clk) begin
    #1;
    begin
      logic [NCH-1:0] e_off;
      logic e_v, e_c;
      e_off = {NCH{~mod_en}} | m_ov | (cc_mode ? '0 : m_oc);
      if (int'(sel_ch) < NCH) begin e_v = m_ov[sel_ch]; e_c = m_oc[sel_ch]; end
      else begin e_v = rmt_ov_flag; e_c = rmt_oc_flag; end
      chk("R2/R3/R4/R10 model chan_off", 32'(chan_off), 32'(e_off));
      chk("R11 model status", {30'd0, stat_ov, stat_oc}, {30'd0, e_v, e_c});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input int ch, input logic ev, input logic ec, input string req);
    sel_ch = AW'(ch);
    #1.5;
    chk(req, {30'd0, stat_ov, stat_oc}, {30'd0, ev, ec});
  endtask

  task automatic cmd(input logic s, input logic a, input int ch);
    cmd_valid = 1'b1; cmd_set = s; cmd_all = a; cmd_ch = AW'(ch);
    tick();
    cmd_valid = 1'b0; cmd_set = 1'b0; cmd_all = 1'b0; cmd_ch = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mod_en = 1'b1; cc_mode = 1'b0; ov_trip = '0; oc_trip = '0;
    cmd_valid = 1'b0; cmd_set = 1'b0; cmd_all = 1'b0; cmd_ch = '0; sel_ch = '0;
    rmt_ov_flag = 1'b0; rmt_oc_flag = 1'b0;
    tick(3);
    #1.5 chk("R1 reset chan_off", 32'(chan_off), 32'h0);
    look(0, 1'b0, 1'b0, "R1 reset status");
    @(negedge clk) rst_n = 1'b1;
    tick(3);

    // R2: one-edge over-voltage pulse on channel 1
    ov_trip[1] = 1'b1; tick(); ov_trip[1] = 1'b0; tick();
    #1.5 chk("R2 not yet off", 32'(chan_off[1]), 32'h0);
    tick();
    #1.5 chk("R2 channel 1 off", 32'(chan_off), 32'h02);
    // R5: stays latched
    tick(4);
    look(1, 1'b1, 1'b0, "R5 ov flag sticky");

    // R3: kill mode over-current on channel 3
    oc_trip[3] = 1'b1; tick(); oc_trip[3] = 1'b0; tick(2);
    #1.5 chk("R3 kill off", 32'(chan_off), 32'h0A);
    look(3, 1'b0, 1'b1, "R3 oc flag");

    // R4: constant-current mode
    tick(); cc_mode = 1'b1;
    #1.5 chk("R4 cc keeps on", 32'(chan_off), 32'h02);
    oc_trip[4] = 1'b1; tick(); oc_trip[4] = 1'b0; tick(3);
    #1.5 chk("R4 cc ch4 on", 32'(chan_off), 32'h02);
    look(4, 1'b0, 1'b1, "R4 oc flag in cc mode");

    // R6: clear channel 1 only
    tick(); cmd(1'b0, 1'b0, 1);
    look(1, 1'b0, 1'b0, "R6 ch1 cleared");
    look(3, 1'b0, 1'b1, "R6 ch3 untouched");

    // R12: out-of-range target
    tick(); cmd(1'b0, 1'b0, 9);
    look(3, 1'b0, 1'b1, "R12 ch3 kept");
    look(4, 1'b0, 1'b1, "R12 ch4 kept");

    // R9: clear-all while channel 0 trip still high
    tick(); oc_trip[0] = 1'b1; tick(3);
    cmd(1'b0, 1'b1, 5);
    look(0, 1'b0, 1'b1, "R9 set wins over clear");
    look(3, 1'b0, 1'b0, "R7 ch3 cleared by all");
    tick(); oc_trip[0] = 1'b0; tick(3);
    cmd(1'b0, 1'b0, 0);
    look(0, 1'b0, 0, "R6 ch0 cleared after trip gone");

    // R8: set one, set all
    tick(); cmd(1'b1, 1'b0, 5);
    look(5, 1'b1, 1'b1, "R8 set ch5");
    #0.5 chk("R8 ch5 off", 32'(chan_off), 32'h20);
    tick(); cmd(1'b1, 1'b1, 0);
    #1.5 chk("R8 set all off", 32'(chan_off), 32'h3F);
    // R7: clear all with arbitrary cmd_ch
    tick(); cmd(1'b0, 1'b1, 2);
    #1.5 chk("R7 all cleared", 32'(chan_off), 32'h00);

    // R10: module disable
    tick(); cmd(1'b1, 1'b0, 2);
    tick(); mod_en = 1'b0;
    #1.5 chk("R10 all off", 32'(chan_off), 32'h3F);
    look(2, 1'b1, 1'b1, "R10 flags kept");
    tick(); mod_en = 1'b1;
    #1.5 chk("R10 re-enable", 32'(chan_off), 32'h04);

    // R11: remote routing
    tick(); rmt_ov_flag = 1'b1; rmt_oc_flag = 1'b0;
    look(7, 1'b1, 1'b0, "R11 remote ov");
    tick(); rmt_ov_flag = 1'b0; rmt_oc_flag = 1'b1;
    look(11, 1'b0, 1'b1, "R11 remote oc");
    look(2, 1'b1, 1'b1, "R11 local ch2");

    // R1: asynchronous reset mid-run
    tick(); cc_mode = 1'b0; cmd(1'b1, 1'b1, 0);
    #1 rst_n = 1'b0;
    #0.5 chk("R1 async clear", 32'(chan_off), 32'h00);
    tick(); rst_n = 1'b1; tick(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule